// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block watches the running calendar time of a real-time clock and raises an alarm when that time reaches a programmed day, hour, minute and second. The current calendar value arrives as one packed BCD word that has the same layout as the alarm value. A one-cycle per-second tick tells the block when that word has just advanced. Software programs the alarm word and sets two enable bits, one for the alarm and one for its interrupt, and clears the alarm flag once it has served the event.

The stored alarm word is protected by a handshake. Software first clears the alarm enable. It then waits for a write-allowed status to rise, which happens a fixed number of cycles later, and only then writes the new alarm word. Any write to the alarm word at another time is dropped. The alarm flag is sticky. The interrupt line is the flag gated by the interrupt enable, so it rises once for each alarm event and software can treat it as an edge.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset the alarm flag, the interrupt, both enable bits, the stored alarm word and the write-allowed status are all 0.
- R2: The alarm word and the calendar word share one layout of four two-digit BCD fields: seconds in bits 7:0, minutes in bits 15:8, hours in bits 23:16 and day in bits 31:24. The stored word can be read back at all times on `alm_value_o`.
- R3: On a clock edge where `sec_tick_i` is 1, the alarm is enabled and all four calendar fields equal the stored fields, the flag is set. It reads 1 from the next cycle on.
- R4: No tick, or a mismatch in any single field, leaves the flag unchanged.
- R5: While the alarm enable is 0, a matching tick does not set the flag.
- R6: Once set, the flag stays at 1 until a cycle with `flag_clr_i` high clears it. If a match and a clear fall in the same cycle, the flag ends up set.
- R7: `alm_irq_o` is 1 exactly when the flag is 1 and the interrupt enable is 1.
- R8: A control write (`ctrl_wr_i`) loads both enable bits. `wr_allowed_o` is 0 in every cycle where the alarm is enabled. After a control write clears the enable, `wr_allowed_o` rises WAIT_CYCLES clock edges later. The same delay applies after reset.
- R9: A write to the alarm word (`alm_wr_i`) takes effect only in a cycle where `wr_allowed_o` is 1. At any other time it is ignored and `alm_value_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse per calendar second |
| cal_time_i | input | 32 | Current calendar day/hour/minute/second in BCD |
| ctrl_wr_i | input | 1 | Load both enable bits |
| ctrl_alm_en_i | input | 1 | New alarm enable value |
| ctrl_irq_en_i | input | 1 | New interrupt enable value |
| alm_wr_i | input | 1 | Write request for the alarm word |
| alm_wdata_i | input | 32 | Alarm word to write, BCD |
| flag_clr_i | input | 1 | Clear the alarm flag |
| alm_value_o | output | 32 | Stored alarm word |
| wr_allowed_o | output | 1 | Alarm word may be written |
| alm_flag_o | output | 1 | Sticky alarm flag |
| alm_irq_o | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach is a full four-field match on a tick while the alarm is enabled. A word of random calendar values almost never equals the stored word, and the stored word can only change during the disabled window. The stimulus therefore often sets the calendar word to the bench's model of the stored word, or flips one bit of it, so that complete matches and single-field misses both occur often. Directed sequences add the cases where a clear and a set land in the same cycle, and where a write arrives just before the write-allowed window opens.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int DIGIT_W  = 4;
  localparam int FIELD_W  = 2 * DIGIT_W;
  localparam int N_FIELDS = 4;
  localparam int WORD_W   = FIELD_W * N_FIELDS;

  typedef logic [FIELD_W-1:0] bcd_field_t;
  typedef logic [WORD_W-1:0]  bcd_word_t;

  // field index 0 = seconds, 1 = minutes, 2 = hours, 3 = day
  function automatic bcd_field_t field_of(bcd_word_t w, int idx);
    return w[idx*FIELD_W +: FIELD_W];
  endfunction

  function automatic logic field_hit(bcd_field_t a, bcd_field_t b);
    return (a == b);
  endfunction
endpackage

// File: rtl/alm_guard.sv
module alm_guard #(
  parameter int WAIT_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic ctrl_alm_en_i,
  input  logic ctrl_irq_en_i,
  output logic alm_en_o,
  output logic irq_en_o,
  output logic wr_allowed_o
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WAIT_CYCLES);

  logic             alm_en_q, irq_en_q;
  logic [CNT_W-1:0] wait_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      alm_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      wait_q   <= '0;
    end else begin
      if (ctrl_wr_i) begin
        alm_en_q <= ctrl_alm_en_i;
        irq_en_q <= ctrl_irq_en_i;
      end
      if (ctrl_wr_i && ctrl_alm_en_i) begin
        wait_q <= '0;
      end else if (!alm_en_q && wait_q != CNT_TOP) begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

  assign alm_en_o     = alm_en_q;
  assign irq_en_o     = irq_en_q;
  assign wr_allowed_o = !alm_en_q && (wait_q == CNT_TOP);
endmodule

// File: rtl/alm_store.sv
module alm_store
  import bcd_alarm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic      allowed_i,
  input  bcd_word_t wdata_i,
  output bcd_word_t value_o
);
  bcd_word_t value_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      value_q <= '0;
    end else if (wr_i && allowed_i) begin
      value_q <= wdata_i;
    end
  end

  assign value_o = value_q;
endmodule

// File: rtl/alm_match.sv
module alm_match
  import bcd_alarm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      alm_en_i,
  input  bcd_word_t cal_i,
  input  bcd_word_t alarm_i,
  input  logic      clr_i,
  output logic      match_o,
  output logic      flag_o
);
  logic [N_FIELDS-1:0] hit;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    assign hit[f] = field_hit(field_of(cal_i, f), field_of(alarm_i, f));
  end

  assign match_o = tick_i && alm_en_i && (&hit);

  logic flag_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (match_o) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
#(
  parameter int WAIT_CYCLES = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sec_tick_i,
  input  logic [31:0] cal_time_i,
  input  logic        ctrl_wr_i,
  input  logic        ctrl_alm_en_i,
  input  logic        ctrl_irq_en_i,
  input  logic        alm_wr_i,
  input  logic [31:0] alm_wdata_i,
  input  logic        flag_clr_i,
  output logic [31:0] alm_value_o,
  output logic        wr_allowed_o,
  output logic        alm_flag_o,
  output logic        alm_irq_o
);
  logic      alm_en, irq_en, match_evt;
  bcd_word_t stored;

  alm_guard #(.WAIT_CYCLES(WAIT_CYCLES)) guard_i (
    .clk_i, .rst_ni, .ctrl_wr_i, .ctrl_alm_en_i, .ctrl_irq_en_i,
    .alm_en_o(alm_en), .irq_en_o(irq_en), .wr_allowed_o(wr_allowed_o)
  );

  alm_store store_i (
    .clk_i, .rst_ni, .wr_i(alm_wr_i), .allowed_i(wr_allowed_o),
    .wdata_i(alm_wdata_i), .value_o(stored)
  );

  alm_match match_i (
    .clk_i, .rst_ni, .tick_i(sec_tick_i), .alm_en_i(alm_en),
    .cal_i(cal_time_i), .alarm_i(stored), .clr_i(flag_clr_i),
    .match_o(match_evt), .flag_o(alm_flag_o)
  );

  assign alm_value_o = stored;
  assign alm_irq_o   = alm_flag_o && irq_en;
endmodule

// File: rtl/bcd_alarm_cmp_chk.sv
module bcd_alarm_cmp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        alm_wr_i,
  input logic        flag_clr_i,
  input logic [31:0] alm_value_o,
  input logic        wr_allowed_o,
  input logic        alm_flag_o,
  input logic        alm_irq_o,
  input logic        alm_en_i,
  input logic        match_evt_i
);
  p_blocked_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alm_wr_i && wr_allowed_o) |=> $stable(alm_value_o));

  p_allow_low_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_en_i |-> !wr_allowed_o);

  p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_irq_o |-> alm_flag_o);

  p_flag_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_evt_i |=> alm_flag_o);

  p_flag_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_flag_o) |-> $past(match_evt_i));

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_flag_o && !flag_clr_i) |=> alm_flag_o);

  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !match_evt_i) |=> !alm_flag_o);
endmodule

bind bcd_alarm_cmp bcd_alarm_cmp_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .alm_wr_i(alm_wr_i), .flag_clr_i(flag_clr_i),
  .alm_value_o(alm_value_o), .wr_allowed_o(wr_allowed_o),
  .alm_flag_o(alm_flag_o), .alm_irq_o(alm_irq_o),
  .alm_en_i(alm_en), .match_evt_i(match_evt)
);

// File: tb/bcd_alarm_cmp_tb_top.sv
`timescale 1ns/1ps
module bcd_alarm_cmp_tb_top;
  localparam int W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, ctrl_wr = 1'b0, ctl_en = 1'b0, ctl_ien = 1'b0;
  logic        awr = 1'b0, clr = 1'b0;
  logic [31:0] cal = '0, wdata = '0;
  logic [31:0] value;
  logic        allowed, flag, irq;

  int checks = 0, fails = 0;

  // reference state
  logic [31:0] m_val;
  logic        m_flag, m_en, m_ien;
  int          m_cnt;

  always #4 clk = ~clk;

  bcd_alarm_cmp #(.WAIT_CYCLES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick), .cal_time_i(cal),
    .ctrl_wr_i(ctrl_wr), .ctrl_alm_en_i(ctl_en), .ctrl_irq_en_i(ctl_ien),
    .alm_wr_i(awr), .alm_wdata_i(wdata), .flag_clr_i(clr),
    .alm_value_o(value), .wr_allowed_o(allowed), .alm_flag_o(flag), .alm_irq_o(irq)
  );

  function automatic bit same_time(logic [31:0] a, logic [31:0] b);
    for (int d = 0; d < 8; d++)
      if (((a >> (4*d)) & 32'hF) != ((b >> (4*d)) & 32'hF)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] rand_bcd();
    logic [31:0] r;
    r[31:24] = {4'(($urandom % 3)), 4'(($urandom % 10))};
    r[23:16] = {4'(($urandom % 3)), 4'(($urandom % 10))};
    r[15:8]  = {4'(($urandom % 6)), 4'(($urandom % 10))};
    r[7:0]   = {4'(($urandom % 6)), 4'(($urandom % 10))};
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R3/R6 flag", 32'(flag), 32'(m_flag));
    check("R7 irq", 32'(irq), 32'(m_flag && m_ien));
    check("R8 allowed", 32'(allowed), 32'(!m_en && m_cnt == W));
    check("R9 value", value, m_val);
  endtask

  // one clock: inputs already set, model advances, outputs compared
  task automatic step();
    bit ok_wr, hit;
    ok_wr = !m_en && m_cnt == W;
    hit   = tick && m_en && same_time(cal, m_val);
    if (hit) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (awr && ok_wr) m_val = wdata;
    if (ctrl_wr && ctl_en) m_cnt = 0;
    else if (!m_en && m_cnt != W) m_cnt++;
    if (ctrl_wr) begin m_en = ctl_en; m_ien = ctl_ien; end
    @(posedge clk);
    @(negedge clk);
    compare_all();
    tick = 0; ctrl_wr = 0; awr = 0; clr = 0;
  endtask

  task automatic set_ctrl(bit en, bit ien);
    ctrl_wr = 1; ctl_en = en; ctl_ien = ien; step();
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] alarm_t;
    void'($urandom(32'd4711));
    m_val = '0; m_flag = 0; m_en = 0; m_ien = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 flag", 32'(flag), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 value", value, 0);
    check("R1 allowed", 32'(allowed), 0);

    // R8 window after reset: W edges
    step(); step();
    check("R8 not yet allowed", 32'(allowed), 0);
    step();
    check("R8 allowed after wait", 32'(allowed), 1);

    // R2 write layout: day 15 hour 23 min 59 sec 58
    alarm_t = 32'h15_23_59_58;
    awr = 1; wdata = alarm_t; step();
    check("R2 readback", value, alarm_t);
    set_ctrl(1, 1);
    check("R8 low when enabled", 32'(allowed), 0);

    // R4 equal but no tick
    cal = alarm_t; step();
    check("R4 no tick", 32'(flag), 0);
    // R4 single field mismatches (each field)
    for (int f = 0; f < 4; f++) begin
      cal = alarm_t ^ (32'h1 << (8*f)); tick = 1; step();
      check("R4 one field off", 32'(flag), 0);
    end
    // R9 write while enabled ignored
    awr = 1; wdata = 32'h01_02_03_04; step();
    check("R9 ignored when enabled", value, alarm_t);
    // R3 full match
    cal = alarm_t; tick = 1; step();
    check("R3 match sets flag", 32'(flag), 1);
    check("R7 irq on", 32'(irq), 1);
    // R6 sticky
    cal = 32'h0; tick = 1; step(); step();
    check("R6 sticky", 32'(flag), 1);
    // R7 gating
    set_ctrl(1, 0);
    check("R7 irq gated", 32'(irq), 0);
    // R6 clear and set in same cycle -> set
    cal = alarm_t; tick = 1; clr = 1; step();
    check("R6 set wins", 32'(flag), 1);
    clr = 1; step();
    check("R6 cleared", 32'(flag), 0);

    // R5 disabled: no set; R8/R9 early write ignored
    set_ctrl(0, 1);
    cal = alarm_t; tick = 1; step();
    check("R5 disabled no set", 32'(flag), 0);
    awr = 1; wdata = 32'h02_03_04_05; step();
    check("R9 early write ignored", value, alarm_t);
    check("R8 still waiting", 32'(allowed), 1'b0);
    step();
    check("R8 open after wait", 32'(allowed), 1);
    awr = 1; wdata = 32'h02_03_04_05; step();
    check("R9 write in window", value, 32'h02_03_04_05);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom % 4;
      if (sel == 0)      cal = rand_bcd();
      else if (sel == 1) cal = m_val ^ (32'h1 << ($urandom % 32));
      else               cal = m_val;
      tick = ($urandom % 3) == 0;
      awr = ($urandom % 5) == 0;
      wdata = rand_bcd();
      clr = ($urandom % 7) == 0;
      ctrl_wr = ($urandom % 12) == 0;
      ctl_en = ($urandom % 2) == 0;
      ctl_ien = ($urandom % 3) != 0;
      step();
    end
    finish_run();
  end
endmodule